// File: doc/BRIEF.md
# Watchdog Frequency Fallback Controller

This block guards an over-clocked operating point. Software arms it with an enable bit and a time limit. A counter then runs down on ticks from one of two time bases, a coarse one and a fine one. Each service strobe (kick) from the system starts the full interval again. If no kick arrives before the interval ends, the block replaces the live 5-bit frequency-select code with a stored safe code. It also raises a sticky alarm flag that software can read.

The block asserts no reset on expiry. The safe code uses the same 5-bit encoding as the main frequency-select field, so code 00000 means the same setting in both places. Software clears the alarm by writing 0 to the status bit. That restores the live code and starts a fresh interval. Registers sit behind a plain write/read port with a one-cycle read latency. The time-base ticks are single-cycle enables on the system clock, supplied from outside.

Top module: `wdog_freq_fallback`

## Requirements
- R1: After reset the control register reads 0x00, the limit register reads 0xFF, the time-base register reads 0x00, `alarm` is 0, and `fs_out` follows `fs_in`.
- R2: Register address 0 is control: bit 6 enable (1 = on), bit 5 status (1 = alarm), bits 4:0 safe code, bit 7 reads 0. Address 1 is the 8-bit limit. Address 2 bit 0 picks the time base (0 = coarse tick, 1 = fine tick), and its other bits read 0. Address 3 reads 0x00. `reg_rdata` shows the register at `reg_addr` one clock after the address is presented.
- R3: With the watchdog enabled and a limit of N, `alarm` rises at the clock edge that samples the (N+1)-th selected tick after the last reload, and not before. A limit of 0xFF therefore needs 256 ticks.
- R4: Only the tick of the selected time base counts. The other tick input has no effect on the expiry point.
- R5: A kick reloads the full interval. A kick in the same cycle as a selected tick still reloads, and that tick is not counted.
- R6: While enable is 0 the counter stays reloaded and no alarm can occur. Re-enabling starts a full interval.
- R7: One clock after `alarm` is 1, `fs_out` equals the stored safe code. While `alarm` is 0, `fs_out` is `fs_in` delayed by one clock.
- R8: The alarm is sticky. Writing status 1 never sets it or clears it. Clearing enable does not clear it. Only a control write with status 0, or a reset, clears it.
- R9: After the alarm is cleared, the next expiry again needs N+1 selected ticks.
- R10: A write to the limit register does not disturb an interval in progress. The new value applies from the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for both write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| tick_coarse | input | 1 | Coarse time-base tick, one cycle wide |
| tick_fine | input | 1 | Fine time-base tick, one cycle wide |
| kick | input | 1 | Service strobe that restarts the interval |
| fs_in | input | 5 | Live frequency-select code |
| fs_out | output | 5 | Effective frequency-select code, registered |
| alarm | output | 1 | Sticky expiry flag |

## Verification
The assertions check the cycle-level rules on every clock:
- the remaining-tick count never leaves its legal range and holds when no selected tick arrives;
- a kick reloads the interval;
- an alarm only rises out of an expiry while enabled, and it stays set without a clearing write;
- `fs_out` carries the safe code one clock after an alarm.

The exact expiry tick count for both time bases, including the 256-tick power-up limit, has to come from the bench scenarios. So do:
- the kick-versus-tick tie;
- limit writes landing in the middle of an interval;
- re-arming after a clear;
- the register read-back layout.

// File: rtl/wdfb_pkg.sv
package wdfb_pkg;
  localparam int REG_ADDR_W = 2;
  typedef enum logic [REG_ADDR_W-1:0] {
    REG_CTRL  = 2'd0,
    REG_LIMIT = 2'd1,
    REG_TBASE = 2'd2,
    REG_SPARE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/wdfb_regs.sv
module wdfb_regs
  import wdfb_pkg::*;
#(
  parameter int FS_W   = 5,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  expire_i,
  output logic [DATA_W-1:0]     rd_data_o,
  output logic                  en_o,
  output logic                  alarm_o,
  output logic [FS_W-1:0]       safe_o,
  output logic [CNT_W-1:0]      limit_o,
  output logic                  fine_o
);
  localparam int ST_BIT = FS_W;
  localparam int EN_BIT = FS_W + 1;

  logic en_q, alarm_q, fine_q;
  logic [FS_W-1:0]   safe_q;
  logic [CNT_W-1:0]  limit_q;
  logic [DATA_W-1:0] rd_q, rd_next;
  logic ctrl_wr, limit_wr, tbase_wr, clear_req;

  assign ctrl_wr   = wr_en && (reg_sel_e'(addr) == REG_CTRL);
  assign limit_wr  = wr_en && (reg_sel_e'(addr) == REG_LIMIT);
  assign tbase_wr  = wr_en && (reg_sel_e'(addr) == REG_TBASE);
  assign clear_req = ctrl_wr && !wr_data[ST_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      alarm_q <= 1'b0;
      safe_q  <= '0;
      limit_q <= '1;
      fine_q  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        en_q   <= wr_data[EN_BIT];
        safe_q <= wr_data[FS_W-1:0];
      end
      if (limit_wr) limit_q <= wr_data[CNT_W-1:0];
      if (tbase_wr) fine_q  <= wr_data[0];
      alarm_q <= expire_i || (alarm_q && !clear_req);
    end
  end

  always_comb begin
    rd_next = '0;
    case (reg_sel_e'(addr))
      REG_CTRL: begin
        rd_next[EN_BIT]     = en_q;
        rd_next[ST_BIT]     = alarm_q;
        rd_next[FS_W-1:0]   = safe_q;
      end
      REG_LIMIT: rd_next[CNT_W-1:0] = limit_q;
      REG_TBASE: rd_next[0]         = fine_q;
      default:   rd_next            = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_next;
  end

  assign rd_data_o = rd_q;
  assign en_o      = en_q;
  assign alarm_o   = alarm_q;
  assign safe_o    = safe_q;
  assign limit_o   = limit_q;
  assign fine_o    = fine_q;

  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (rst)
    (alarm_q && !clear_req) |=> alarm_q); // R8
  AST_ALARM_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (!alarm_q && !expire_i) |=> !alarm_q); // R3
  AST_OFF_NO_ALARM: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !alarm_q) |=> !alarm_q); // R6
endmodule

// File: rtl/wdfb_countdown.sv
module wdfb_countdown #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             alarm_i,
  input  logic             fine_i,
  input  logic             tick_coarse_i,
  input  logic             tick_fine_i,
  input  logic             kick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);
  localparam int REM_W = CNT_W + 1;
  localparam logic [REM_W-1:0] REM_MAX = REM_W'(1) << CNT_W;

  logic [REM_W-1:0] rem_q, full_load;
  logic tick_sel, reload, step;

  assign tick_sel  = fine_i ? tick_fine_i : tick_coarse_i;
  assign full_load = REM_W'(limit_i) + REM_W'(1);
  assign reload    = !en_i || kick_i || alarm_i;
  assign step      = !reload && tick_sel;
  assign expire_o  = step && (rem_q == REM_W'(1));

  always_ff @(posedge clk) begin
    if (rst)             rem_q <= REM_MAX;
    else if (reload)     rem_q <= full_load;
    else if (expire_o)   rem_q <= full_load;
    else if (step)       rem_q <= rem_q - REM_W'(1);
  end

  AST_REM_RANGE: assert property (@(posedge clk) disable iff (rst)
    (rem_q != '0) && (rem_q <= REM_MAX)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (en_i && !alarm_i && !kick_i && !tick_sel) |=> $stable(rem_q)); // R4
  AST_KICK_RELOAD: assert property (@(posedge clk) disable iff (rst)
    kick_i |=> (rem_q == REM_W'($past(limit_i)) + REM_W'(1))); // R5
endmodule

// File: rtl/wdfb_select.sv
module wdfb_select #(
  parameter int FS_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            alarm_i,
  input  logic [FS_W-1:0] safe_i,
  input  logic [FS_W-1:0] fs_i,
  output logic [FS_W-1:0] fs_o
);
  logic [FS_W-1:0] pick, fs_q;

  for (genvar b = 0; b < FS_W; b++) begin : g_bit
    assign pick[b] = alarm_i ? safe_i[b] : fs_i[b];
  end

  always_ff @(posedge clk) begin
    if (rst) fs_q <= fs_i;
    else     fs_q <= pick;
  end

  assign fs_o = fs_q;
endmodule

// File: rtl/wdog_freq_fallback.sv
module wdog_freq_fallback
  import wdfb_pkg::*;
#(
  parameter int FS_W   = 5,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic                  tick_coarse,
  input  logic                  tick_fine,
  input  logic                  kick,
  input  logic [FS_W-1:0]       fs_in,
  output logic [FS_W-1:0]       fs_out,
  output logic                  alarm
);
  logic en_w, alarm_w, fine_w, expire_w;
  logic [FS_W-1:0]  safe_w;
  logic [CNT_W-1:0] limit_w;

  wdfb_regs #(.FS_W(FS_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wr_data(reg_wdata),
    .expire_i(expire_w), .rd_data_o(reg_rdata), .en_o(en_w), .alarm_o(alarm_w),
    .safe_o(safe_w), .limit_o(limit_w), .fine_o(fine_w)
  );

  wdfb_countdown #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .en_i(en_w), .alarm_i(alarm_w), .fine_i(fine_w),
    .tick_coarse_i(tick_coarse), .tick_fine_i(tick_fine), .kick_i(kick),
    .limit_i(limit_w), .expire_o(expire_w)
  );

  wdfb_select #(.FS_W(FS_W)) u_sel (
    .clk(clk), .rst(rst), .alarm_i(alarm_w), .safe_i(safe_w), .fs_i(fs_in),
    .fs_o(fs_out)
  );

  assign alarm = alarm_w;

  AST_FS_FORCED: assert property (@(posedge clk) disable iff (rst)
    alarm |=> (fs_out == $past(safe_w))); // R7
  AST_FS_PASS: assert property (@(posedge clk) disable iff (rst)
    !alarm |=> (fs_out == $past(fs_in))); // R7
endmodule

// File: tb/tb_wdog_freq_fallback.sv
module tb_wdog_freq_fallback;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic tick_coarse = 1'b0, tick_fine = 1'b0, kick = 1'b0;
  logic [4:0] fs_in = 5'h0A;
  logic [4:0] fs_out;
  logic alarm;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  wdog_freq_fallback dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_coarse(tick_coarse),
    .tick_fine(tick_fine), .kick(kick), .fs_in(fs_in), .fs_out(fs_out),
    .alarm(alarm)
  );

  function automatic logic [4:0] exp_fs(logic al, logic [4:0] safe, logic [4:0] live);
    return al ? safe : live;
  endfunction

  function automatic int exp_ticks(int limit);
    return limit + 1;
  endfunction

  function automatic logic [7:0] ctrl_byte(logic en, logic st, logic [4:0] safe);
    return {1'b0, en, st, safe};
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(string req, logic [1:0] a, logic [7:0] exp);
    reg_addr = a;
    @(negedge clk);
    check(req, reg_rdata, exp);
  endtask

  task automatic pulse(logic c, logic f, logic k);
    tick_coarse = c; tick_fine = f; kick = k;
    @(negedge clk);
    tick_coarse = 1'b0; tick_fine = 1'b0; kick = 1'b0;
  endtask

  task automatic sel_tick(logic fine);
    pulse(!fine, fine, 1'b0);
  endtask

  task automatic arm(int limit, logic fine, logic [4:0] safe);
    wr(2'd0, ctrl_byte(1'b0, 1'b0, safe));
    wr(2'd1, 8'(limit));
    wr(2'd2, {7'b0, fine});
    wr(2'd0, ctrl_byte(1'b1, 1'b0, safe));
  endtask

  task automatic run_expiry(int limit, logic fine, logic [4:0] safe, logic [4:0] live);
    int need = exp_ticks(limit);
    fs_in = live;
    arm(limit, fine, safe);
    for (int i = 0; i < need - 1; i++) begin
      sel_tick(fine);
      pulse(fine, !fine, 1'b0);
    end
    check("R3 no alarm before limit+1 ticks", alarm, 0);
    check("R4 other tick ignored", alarm, 0);
    check("R7 pass-through while normal", fs_out, exp_fs(1'b0, safe, live));
    sel_tick(fine);
    check("R3 alarm at limit+1 ticks", alarm, 1);
    @(negedge clk);
    check("R7 safe code forced", fs_out, exp_fs(1'b1, safe, live));
    rd_check("R2 status bit reads alarm", 2'd0, ctrl_byte(1'b1, 1'b1, safe));
    wr(2'd0, ctrl_byte(1'b0, 1'b1, safe));
    check("R8 disable keeps alarm", alarm, 1);
    wr(2'd0, ctrl_byte(1'b0, 1'b0, safe));
    check("R8 status write 0 clears", alarm, 0);
    @(negedge clk);
    check("R7 live code restored", fs_out, live);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 alarm after reset", alarm, 0);
    check("R1 fs_out follows fs_in", fs_out, 5'h0A);
    rd_check("R1 control reset", 2'd0, 8'h00);
    rd_check("R1 limit reset", 2'd1, 8'hFF);
    rd_check("R1 time base reset", 2'd2, 8'h00);
    rd_check("R2 spare address", 2'd3, 8'h00);

    wr(2'd2, 8'hFF);
    rd_check("R2 time base bit only", 2'd2, 8'h01);
    wr(2'd0, 8'hFF);
    rd_check("R2 R8 control readback, status write 1 ignored", 2'd0, 8'h5F);
    check("R8 status write 1 does not set", alarm, 0);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h00);

    run_expiry(3, 1'b0, 5'h15, 5'h02);
    run_expiry(5, 1'b1, 5'h00, 5'h1C);
    run_expiry(0, 1'b0, 5'h07, 5'h11);
    run_expiry(255, 1'b1, 5'h1E, 5'h03);

    // R5: kick reloads, including kick tied with a tick
    arm(4, 1'b0, 5'h09);
    repeat (3) sel_tick(1'b0);
    pulse(1'b0, 1'b0, 1'b1);
    repeat (4) sel_tick(1'b0);
    pulse(1'b1, 1'b0, 1'b1);
    repeat (4) sel_tick(1'b0);
    check("R5 kick restarts interval", alarm, 0);
    sel_tick(1'b0);
    check("R5 expiry after reload", alarm, 1);
    wr(2'd0, 8'h00);

    // R6: disabled counts nothing; re-enable restarts
    wr(2'd1, 8'd2);
    repeat (10) sel_tick(1'b0);
    check("R6 no alarm while disabled", alarm, 0);
    wr(2'd0, ctrl_byte(1'b1, 1'b0, 5'h04));
    repeat (2) sel_tick(1'b0);
    wr(2'd0, ctrl_byte(1'b0, 1'b0, 5'h04));
    wr(2'd0, ctrl_byte(1'b1, 1'b0, 5'h04));
    repeat (2) sel_tick(1'b0);
    check("R6 re-enable gives full interval", alarm, 0);
    sel_tick(1'b0);
    check("R6 expiry after re-enable", alarm, 1);

    // R9: clear while enabled, full interval again
    wr(2'd0, ctrl_byte(1'b1, 1'b0, 5'h04));
    check("R9 cleared", alarm, 0);
    repeat (2) sel_tick(1'b0);
    check("R9 no early re-expiry", alarm, 0);
    sel_tick(1'b0);
    check("R9 re-expiry at limit+1", alarm, 1);
    wr(2'd0, 8'h00);

    // R10: limit change applies from next reload
    arm(3, 1'b1, 5'h12);
    sel_tick(1'b1);
    wr(2'd1, 8'd10);
    repeat (2) sel_tick(1'b1);
    check("R10 old interval still running", alarm, 0);
    sel_tick(1'b1);
    check("R10 expiry on old limit", alarm, 1);
    wr(2'd0, ctrl_byte(1'b1, 1'b0, 5'h12));
    repeat (10) sel_tick(1'b1);
    check("R10 new limit not yet reached", alarm, 0);
    sel_tick(1'b1);
    check("R10 expiry on new limit", alarm, 1);
    wr(2'd0, 8'h00);

    // Random phase against a bench model
    begin
      int limit = 0;
      int rem = 0;
      logic m_alarm = 1'b0;
      logic fine = 1'b0;
      logic [4:0] safe = 5'h0;
      for (int blk = 0; blk < 6; blk++) begin
        limit = int'($urandom % 6);
        fine = 1'($urandom % 2);
        safe = 5'($urandom);
        arm(limit, fine, safe);
        rem = exp_ticks(limit);
        m_alarm = 1'b0;
        for (int s = 0; s < 60; s++) begin
          int act = int'($urandom % 4);
          logic prev_alarm = m_alarm;
          logic [4:0] live = 5'($urandom);
          fs_in = live;
          if (m_alarm && act == 3) begin
            wr(2'd0, ctrl_byte(1'b1, 1'b0, safe));
            m_alarm = 1'b0;
            rem = exp_ticks(limit);
            check("R9 random clear", alarm, 0);
            continue;
          end
          case (act)
            0: pulse(!fine, fine, 1'b0);
            1: pulse(fine, !fine, 1'b0);
            2: pulse(1'($urandom % 2) ^ fine ? 1'b0 : !fine, 1'b0, 1'b1);
            default: @(negedge clk);
          endcase
          if (!m_alarm) begin
            if (act == 2) rem = exp_ticks(limit);
            else if (act == 0) begin
              rem--;
              if (rem == 0) begin
                m_alarm = 1'b1;
                rem = exp_ticks(limit);
              end
            end
          end
          check("R3 R4 R5 random alarm", alarm, m_alarm);
          check("R7 random fs_out", fs_out, exp_fs(prev_alarm, safe, live));
        end
        wr(2'd0, 8'h00);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule